// File: doc/BRIEF.md
# Video Controller Register File with Reset Hold

This block is the processor-facing register file of a tile-based video controller, together with the dot and scanline counters that track the frame position. A 3-bit select, separate read and write strobes and an 8-bit data bus reach eight registers:

| Select | Register |
|---|---|
| 0 | control |
| 1 | mask |
| 2 | status |
| 3 | sprite address |
| 4 | sprite data |
| 5 | scroll |
| 6 | address |
| 7 | data port |

The data port drives a simple video-memory interface. That interface has an address, a write pulse and write data, and it takes read data back.

The block covers how the registers behave at power-up and after a warm reset. Both resets set an internal hold latch. While the latch is set, writes to the control, mask, scroll and address registers are discarded, and the shared first/second write toggle stays frozen. The latch stays set until the frame counter reaches the second dot of the pre-render scanline. The other registers work from the first cycle.

A cold reset clears everything. A warm reset keeps the following:

- the current video address
- the sprite address
- the status flags

Top module: `vid_regfile`

## Requirements
- R1: After a cold reset the control, mask, temporary address, fine-X and write toggle are zero. The current video address, sprite address, read buffer and status flags are also zero. The counters show scanline 0 dot 0 and the hold latch is set.
- R2: The dot counter runs 0..340 and the scanline counter runs 0..261, one dot per clock, with scanline advancing when dot wraps. Either reset restarts them at scanline 0, dot 0.
- R3: Either reset sets the hold latch (hold_o=1). The latch clears on the clock edge at which the counters show scanline 261, dot 1, and at no other time.
- R4: While the hold latch is set, writes to selects 0, 1, 5 and 6 change nothing, including the write toggle. A write at the edge where the latch clears is dropped; a write on the next edge is accepted.
- R5: Selects 2, 3, 4 and 7 operate normally while the hold latch is set.
- R6: The vertical-blank flag sets on the edge where the counters show scanline 241, dot 0. Reading select 2 returns {vblank, sprite0_hit, sprite_overflow, 5'b0}, then clears the vertical-blank flag and the write toggle.
- R7: The edge at scanline 261, dot 1 clears vblank, sprite0_hit and sprite_overflow. Pulses on spr0_hit_in and spr_ovf_in set the latter two.
- R8: A warm reset keeps the current video address, the sprite address and all status flags. It clears control, mask, temporary address, fine-X, toggle and the read buffer.
- R9: A scroll write with toggle 0 loads fine-X from wdata[2:0] and temp[4:0] from wdata[7:3]. A scroll write with toggle 1 loads temp[14:12] from wdata[2:0] and temp[9:5] from wdata[7:3]. Each write flips the toggle.
- R10: An address write with toggle 0 loads temp[13:8] from wdata[5:0] and clears temp[14]. An address write with toggle 1 loads temp[7:0] from wdata and copies the full result into the current video address. Each write flips the toggle.
- R11: A data-port write pulses vmem_we with vmem_addr equal to the current address. A data-port read returns the read buffer, then loads the buffer from vmem_rdata. Both advance the address by 32 when control bit 2 is set and by 1 otherwise. A control write also loads temp[11:10] from wdata[1:0].
- R12: A sprite-data write stores the byte at the sprite address and increments the address. A sprite-data read returns the stored byte and does not increment the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| cold_rst | input | 1 | Synchronous power-on reset, active high |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| bus_sel | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| spr0_hit_in | input | 1 | Sets the sprite-0 hit flag |
| spr_ovf_in | input | 1 | Sets the sprite-overflow flag |
| vmem_rdata | input | 8 | Video memory data at vmem_addr |
| vmem_we | output | 1 | Video memory write pulse |
| vmem_wdata | output | 8 | Video memory write data |
| vmem_addr | output | 15 | Current video address |
| ctrl_o | output | 8 | Control register |
| mask_o | output | 8 | Mask register |
| tmp_addr_o | output | 15 | Temporary scroll/address register |
| fine_x_o | output | 3 | Fine horizontal scroll |
| wr_toggle_o | output | 1 | First/second write toggle |
| hold_o | output | 1 | Reset-hold latch |
| dot_o | output | 9 | Dot counter |
| line_o | output | 9 | Scanline counter |

## Verification
The write-gating function is exercised with three patterns of register writes.

- **Writes during the hold window.** The bench writes every gated register while the hold latch is set. It then writes the same registers at the exact edge where the latch releases, and again one edge later. This separates a latch that releases a cycle early or late from a correct one.
- **Ungated registers during the hold window.** Accesses to the sprite, status and data-port registers during the hold window show that the gating does not spread to them.
- **Warm reset after vertical blank has set.** A warm reset issued just after vertical blank sets shows which state survives a warm reset and which is cleared.

Paired scroll and address writes, with a status read placed between them, check the toggle sequencing. They also check the bit placement in the temporary address.

// File: rtl/vid_regfile.sv
module vid_regfile #(
  parameter int DOTS     = 341,
  parameter int LINES    = 262,
  parameter int VBL_LINE = 241,
  parameter int PRE_LINE = 261,
  parameter int REL_DOT  = 1
) (
  input  logic                       clk,
  input  logic                       cold_rst,
  input  logic                       warm_rst,
  input  logic [2:0]                 bus_sel,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [7:0]                 bus_wdata,
  output logic [7:0]                 bus_rdata,
  input  logic                       spr0_hit_in,
  input  logic                       spr_ovf_in,
  input  logic [7:0]                 vmem_rdata,
  output logic                       vmem_we,
  output logic [7:0]                 vmem_wdata,
  output logic [14:0]                vmem_addr,
  output logic [7:0]                 ctrl_o,
  output logic [7:0]                 mask_o,
  output logic [14:0]                tmp_addr_o,
  output logic [2:0]                 fine_x_o,
  output logic                       wr_toggle_o,
  output logic                       hold_o,
  output logic [$clog2(DOTS)-1:0]    dot_o,
  output logic [$clog2(LINES)-1:0]   line_o
);
  localparam int DW = $clog2(DOTS);
  localparam int LW = $clog2(LINES);
  localparam logic [DW-1:0] DOT_LAST  = DW'(DOTS - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(LINES - 1);
  localparam logic [LW-1:0] VBL_L     = LW'(VBL_LINE);
  localparam logic [LW-1:0] PRE_L     = LW'(PRE_LINE);
  localparam logic [DW-1:0] REL_D     = DW'(REL_DOT);

  localparam logic [2:0] S_CTRL = 3'd0, S_MASK = 3'd1, S_STAT = 3'd2, S_SADR = 3'd3;
  localparam logic [2:0] S_SDAT = 3'd4, S_SCRL = 3'd5, S_ADDR = 3'd6, S_DATA = 3'd7;

  logic [DW-1:0] dot;
  logic [LW-1:0] line;
  logic          hold;
  logic [7:0]    ctrl, mask;
  logic [14:0]   tmp, vaddr;
  logic [2:0]    fine_x;
  logic          toggle;
  logic          vb, s0, ovf;
  logic [7:0]    spr_addr;
  logic [7:0]    spr_mem [256];
  logic [7:0]    rbuf;

  wire any_rst  = cold_rst | warm_rst;
  wire pre_evt  = (line == PRE_L) && (dot == REL_D);
  wire vbl_evt  = (line == VBL_L) && (dot == '0);
  wire wr_ctrl  = bus_wr && bus_sel == S_CTRL;
  wire wr_mask  = bus_wr && bus_sel == S_MASK;
  wire wr_sadr  = bus_wr && bus_sel == S_SADR;
  wire wr_sdat  = bus_wr && bus_sel == S_SDAT;
  wire wr_scrl  = bus_wr && bus_sel == S_SCRL;
  wire wr_addr  = bus_wr && bus_sel == S_ADDR;
  wire wr_data  = bus_wr && bus_sel == S_DATA;
  wire rd_stat  = bus_rd && bus_sel == S_STAT;
  wire rd_data  = bus_rd && bus_sel == S_DATA;
  wire [14:0] step = ctrl[2] ? 15'd32 : 15'd1;

  always_ff @(posedge clk) begin
    if (any_rst) begin
      dot  <= '0;
      line <= '0;
    end else if (dot == DOT_LAST) begin
      dot  <= '0;
      line <= (line == LINE_LAST) ? '0 : line + 1'b1;
    end else begin
      dot <= dot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (any_rst)      hold <= 1'b1;
    else if (pre_evt) hold <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (any_rst || hold) begin
      ctrl   <= '0;
      mask   <= '0;
      tmp    <= '0;
      fine_x <= '0;
      toggle <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl        <= bus_wdata;
        tmp[11:10]  <= bus_wdata[1:0];
      end
      if (wr_mask) mask <= bus_wdata;
      if (wr_scrl) begin
        toggle <= ~toggle;
        if (!toggle) begin
          fine_x   <= bus_wdata[2:0];
          tmp[4:0] <= bus_wdata[7:3];
        end else begin
          tmp[14:12] <= bus_wdata[2:0];
          tmp[9:5]   <= bus_wdata[7:3];
        end
      end
      if (wr_addr) begin
        toggle <= ~toggle;
        if (!toggle) begin
          tmp[13:8] <= bus_wdata[5:0];
          tmp[14]   <= 1'b0;
        end else begin
          tmp[7:0]  <= bus_wdata;
        end
      end
      if (rd_stat) toggle <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (cold_rst)
      vaddr <= '0;
    else if (!warm_rst) begin
      if (!hold && wr_addr && toggle) vaddr <= {tmp[14:8], bus_wdata};
      else if (wr_data || rd_data)    vaddr <= vaddr + step;
    end
  end

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      vb  <= 1'b0;
      s0  <= 1'b0;
      ovf <= 1'b0;
    end else if (!warm_rst) begin
      if (pre_evt) begin
        vb  <= 1'b0;
        s0  <= 1'b0;
        ovf <= 1'b0;
      end else begin
        if (vbl_evt)      vb <= 1'b1;
        else if (rd_stat) vb <= 1'b0;
        if (spr0_hit_in) s0  <= 1'b1;
        if (spr_ovf_in)  ovf <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cold_rst)
      spr_addr <= '0;
    else if (!warm_rst) begin
      if (wr_sadr)      spr_addr <= bus_wdata;
      else if (wr_sdat) spr_addr <= spr_addr + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!any_rst && wr_sdat) spr_mem[spr_addr] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (any_rst)      rbuf <= '0;
    else if (rd_data) rbuf <= vmem_rdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_sel)
        S_STAT:  bus_rdata = {vb, s0, ovf, 5'b0};
        S_SDAT:  bus_rdata = spr_mem[spr_addr];
        S_DATA:  bus_rdata = rbuf;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign vmem_we     = wr_data && !any_rst;
  assign vmem_wdata  = bus_wdata;
  assign vmem_addr   = vaddr;
  assign ctrl_o      = ctrl;
  assign mask_o      = mask;
  assign tmp_addr_o  = tmp;
  assign fine_x_o    = fine_x;
  assign wr_toggle_o = toggle;
  assign hold_o      = hold;
  assign dot_o       = dot;
  assign line_o      = line;

  a_r2_counter_range: assert property (@(posedge clk) disable iff (any_rst)
    dot <= DOT_LAST && line <= LINE_LAST);

  a_r3_hold_release: assert property (@(posedge clk) disable iff (any_rst)
    pre_evt |=> !hold);

  a_r3_hold_only_at_release: assert property (@(posedge clk) disable iff (any_rst)
    $fell(hold) |-> $past(pre_evt));

  a_r4_frozen_while_held: assert property (@(posedge clk) disable iff (any_rst)
    hold |-> (ctrl == '0 && mask == '0 && tmp == '0 && fine_x == '0 && !toggle));

  a_r6_vblank_sets: assert property (@(posedge clk) disable iff (any_rst)
    vbl_evt |=> vb);

  a_r7_flags_cleared: assert property (@(posedge clk) disable iff (any_rst)
    pre_evt |=> !(vb || s0 || ovf));

  a_r12_spr_addr_step: assert property (@(posedge clk) disable iff (any_rst)
    wr_sdat |=> spr_addr == $past(spr_addr) + 8'd1);
endmodule

// File: tb/vid_regfile_tb.sv
module vid_regfile_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        cold_rst = 1'b1, warm_rst = 1'b0;
  logic [2:0]  bus_sel = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic        spr0_hit_in = 1'b0, spr_ovf_in = 1'b0;
  logic [7:0]  vmem_rdata = 8'h5A;
  logic        vmem_we;
  logic [7:0]  vmem_wdata;
  logic [14:0] vmem_addr;
  logic [7:0]  ctrl_o, mask_o;
  logic [14:0] tmp_addr_o;
  logic [2:0]  fine_x_o;
  logic        wr_toggle_o, hold_o;
  logic [8:0]  dot_o, line_o;

  vid_regfile u_dut (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spr0_hit_in(spr0_hit_in), .spr_ovf_in(spr_ovf_in),
    .vmem_rdata(vmem_rdata), .vmem_we(vmem_we), .vmem_wdata(vmem_wdata),
    .vmem_addr(vmem_addr), .ctrl_o(ctrl_o), .mask_o(mask_o),
    .tmp_addr_o(tmp_addr_o), .fine_x_o(fine_x_o), .wr_toggle_o(wr_toggle_o),
    .hold_o(hold_o), .dot_o(dot_o), .line_o(line_o)
  );

  int errors = 0, checks = 0, pos = 0;
  localparam int DOTS = 341;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (pos %0d)", req, act, exp, pos);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    pos++;
    @(negedge clk);
    #1;
  endtask

  task automatic advance_to(input int target);
    while (pos < target) tick();
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] d);
    bus_sel = s; bus_rd = 1'b1;
    #1 d = bus_rdata;
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic t_cold_state();
    logic [7:0] d;
    chk("R1 ctrl", ctrl_o, 0);
    chk("R1 mask", mask_o, 0);
    chk("R1 tmp", tmp_addr_o, 0);
    chk("R1 fine_x", fine_x_o, 0);
    chk("R1 toggle", wr_toggle_o, 0);
    chk("R1 vaddr", vmem_addr, 0);
    chk("R1 hold", hold_o, 1);
    chk("R1 dot", dot_o, 0);
    chk("R1 line", line_o, 0);
    rd(3'd2, d); chk("R1 status", d, 8'h00);
    rd(3'd7, d); chk("R1 read buffer", d, 8'h00);
    rd(3'd7, d); chk("R11 buffered read", d, 8'h5A);
    chk("R11 increment by 1", vmem_addr, 15'd2);
  endtask

  task automatic t_hold_drop();
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'h1E);
    wr(3'd5, 8'h7D);
    wr(3'd6, 8'h3F);
    wr(3'd6, 8'h12);
    chk("R4 ctrl dropped", ctrl_o, 0);
    chk("R4 mask dropped", mask_o, 0);
    chk("R4 tmp dropped", tmp_addr_o, 0);
    chk("R4 fine_x dropped", fine_x_o, 0);
    chk("R4 toggle frozen", wr_toggle_o, 0);
    chk("R4 vaddr untouched", vmem_addr, 15'd2);
  endtask

  task automatic t_hold_live();
    logic [7:0] d;
    wr(3'd3, 8'h10);
    wr(3'd4, 8'hA5);
    wr(3'd4, 8'h3C);
    wr(3'd3, 8'h11);
    rd(3'd4, d); chk("R12 sprite read", d, 8'h3C);
    rd(3'd4, d); chk("R12 read no increment", d, 8'h3C);
    wr(3'd3, 8'h10);
    rd(3'd4, d); chk("R5 sprite data in hold", d, 8'hA5);
    wr(3'd3, 8'h11);
    bus_sel = 3'd7; bus_wdata = 8'h77; bus_wr = 1'b1;
    #1;
    chk("R11 vmem_we pulse", vmem_we, 1);
    chk("R11 vmem_addr", vmem_addr, 15'd2);
    chk("R11 vmem_wdata", vmem_wdata, 8'h77);
    tick();
    bus_wr = 1'b0;
    chk("R5 data port in hold", vmem_addr, 15'd3);
    spr0_hit_in = 1'b1; tick(); spr0_hit_in = 1'b0;
    rd(3'd2, d); chk("R5 status in hold", d, 8'h40);
  endtask

  task automatic t_vblank_warm();
    logic [7:0] d;
    advance_to(241 * DOTS);
    rd(3'd2, d); chk("R6 vblank not yet set", d, 8'h40);
    spr_ovf_in = 1'b1; tick(); spr_ovf_in = 1'b0;
    warm_rst = 1'b1; tick(); warm_rst = 1'b0;
    pos = 0;
    chk("R2 restart dot", dot_o, 0);
    chk("R2 restart line", line_o, 0);
    chk("R3 hold set by warm reset", hold_o, 1);
    chk("R8 vaddr kept", vmem_addr, 15'd3);
    chk("R8 ctrl cleared", ctrl_o, 0);
    rd(3'd2, d); chk("R8 flags kept, R6 vblank set", d, 8'hE0);
    rd(3'd2, d); chk("R6 status read clears vblank", d, 8'h60);
    rd(3'd4, d); chk("R8 sprite address kept", d, 8'h3C);
    rd(3'd7, d); chk("R8 read buffer cleared", d, 8'h00);
    advance_to(340);
    chk("R2 last dot", dot_o, 340);
    tick();
    chk("R2 dot wraps", dot_o, 0);
    chk("R2 line advances", line_o, 1);
    advance_to(3 * DOTS + 5);
    chk("R2 dot count", dot_o, 5);
    chk("R2 line count", line_o, 3);
  endtask

  task automatic t_release_edge();
    logic [7:0] d;
    advance_to(261 * DOTS + 1);
    chk("R3 hold before release", hold_o, 1);
    wr(3'd0, 8'h04);
    chk("R3 hold released", hold_o, 0);
    chk("R4 write at release edge dropped", ctrl_o, 0);
    wr(3'd0, 8'h04);
    chk("R4 write after release accepted", ctrl_o, 8'h04);
    rd(3'd2, d); chk("R7 flags cleared", d, 8'h00);
  endtask

  task automatic t_scroll();
    wr(3'd5, 8'h7D);
    chk("R9 fine_x", fine_x_o, 3'd5);
    chk("R9 first scroll tmp", tmp_addr_o, 15'h000F);
    chk("R9 toggle set", wr_toggle_o, 1);
    wr(3'd5, 8'h5E);
    chk("R9 second scroll tmp", tmp_addr_o, 15'h616F);
    chk("R9 toggle back", wr_toggle_o, 0);
  endtask

  task automatic t_addr();
    logic [7:0] d;
    wr(3'd6, 8'h7F);
    chk("R10 first addr write", tmp_addr_o, 15'h3F6F);
    chk("R10 toggle set", wr_toggle_o, 1);
    rd(3'd2, d);
    chk("R6 status read clears toggle", wr_toggle_o, 0);
    wr(3'd6, 8'h21);
    wr(3'd6, 8'h80);
    chk("R10 tmp full", tmp_addr_o, 15'h2180);
    chk("R10 vaddr copied", vmem_addr, 15'h2180);
  endtask

  task automatic t_increment();
    logic [7:0] d;
    wr(3'd7, 8'h11);
    chk("R11 increment by 32", vmem_addr, 15'h21A0);
    wr(3'd0, 8'h03);
    chk("R11 ctrl loads tmp[11:10]", tmp_addr_o, 15'h2D80);
    rd(3'd7, d); chk("R11 buffer returned", d, 8'h5A);
    chk("R11 increment by 1 again", vmem_addr, 15'h21A1);
    wr(3'd1, 8'h1E);
    chk("R4 mask accepted after release", mask_o, 8'h1E);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    cold_rst = 1'b0;
    #1;
    pos = 0;
    t_cold_state();
    t_hold_drop();
    t_hold_live();
    t_vblank_warm();
    t_release_edge();
    t_scroll();
    t_addr();
    t_increment();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule